// File: doc/BRIEF.md
# Three-Stage Decimating FIR Cascade

This block runs three low-pass FIR filters in series, each with its own decimation ratio. All arithmetic is done by one multiply-accumulate engine, which is shared over time. It serves one filter at a time and spends one cycle per tap on each output sample. Every filter takes its coefficients from one shared coefficient RAM. The coefficient sets lie one after another in that RAM. A filter's first coefficient sits at the sum of the tap counts of the filters ahead of it.

Software loads the RAM in two steps. It first writes a start address, normally zero. It then streams 24-bit two's-complement coefficients through a data port, and each data write moves the address on by one. The coefficients go in filter-by-filter: all of filter 1, then filter 2, then filter 3.

Each filter has four settings: an enable, a 9-bit tap count, a 4-bit decimation ratio and a 2-bit rounding mode. A typical setup decimates by 2 in every filter, with rounding on in filters 1 and 3 and truncation in filter 2. Samples enter and leave with a valid strobe. An overflow strobe reports a sample that arrived while a computation was still in progress.

Top module: `fir_cascade3`

## Requirements
- R1: A pulse on `coef_addr_ld` sets the coefficient pointer to `coef_addr`. Each `coef_wr` stores `coef_data` at the pointer and advances the pointer by one. Filter f (0, 1, 2) reads its coefficient k at address base_f + k, where base_0 = 0, base_1 = T0 and base_2 = T0 + T1 (Tf is the tap count of filter f).
- R2: An enabled filter with tap count T and decimation field D stores every sample it receives. Field values 0 and 1 both mean a ratio of 1. After every max(D,1) stored samples, the filter produces sum over k = 0..T-1 of c[base+k]·x[n−k]. Here x[n] is the newest stored sample, and samples older than those stored since reset count as zero.
- R3: A rounding mode of 0 takes the accumulator shifted arithmetically right by 23 (truncation toward minus infinity). Modes 1, 2 and 3 add 2^22 before the shift.
- R4: Each filter result is saturated to the range −2^23 … 2^23−1.
- R5: A disabled filter passes each sample unchanged to the next filter without decimating. With all three disabled, `out_data` equals `in_data`.
- R6: The output of filter 1 feeds filter 2, and the output of filter 2 feeds filter 3. `out_valid` is a one-cycle pulse that carries the filter 3 result, and results leave in input order.
- R7: `cfg_reject` is high when any of these holds: the three tap counts sum to 336 or more (enabled or not), any tap count exceeds 128, or an enabled filter has zero taps. While it is high, input samples are ignored. They cause no output and change no stored sample or decimation count.
- R8: A sample strobed while a computation is in progress is discarded, and `ovf` pulses in the next cycle.
- R9: After reset, `out_valid` and `ovf` are low, every filter history is empty (reads as zero) and every decimation count is zero.
- R10: Computing one filter output takes exactly T multiply-accumulate cycles. When every filter is enabled with a ratio of 1, the output appears T0+T1+T2+5 clock edges after the edge that samples the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 3 | Per-filter enable, bit f for filter f |
| cfg_taps | input | 27 | Tap counts, 9 bits per filter, filter f at bits 9f+8:9f |
| cfg_dec | input | 12 | Decimation ratios, 4 bits per filter, filter f at bits 4f+3:4f |
| cfg_rnd | input | 6 | Rounding modes, 2 bits per filter, filter f at bits 2f+1:2f |
| cfg_reject | output | 1 | Configuration is invalid and inputs are ignored |
| coef_addr_ld | input | 1 | Load the coefficient pointer |
| coef_addr | input | 9 | Value for the coefficient pointer |
| coef_wr | input | 1 | Write a coefficient at the pointer and advance the pointer |
| coef_data | input | 24 | Coefficient, two's complement |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Output sample, two's complement |
| ovf | output | 1 | Pulse: an input sample was dropped because the engine was busy |

## Verification
A new input strobe can land in the same cycle as a multiply-accumulate step that is still running for an earlier sample. In that cycle the acceptance of the new input competes with the ongoing computation. The bench provokes this by holding the input strobe for two consecutive cycles, with the first sample completing a decimation period. It judges the result in two ways. A reference model, which is told that only the first sample was taken, must match every later output. Exactly one overflow pulse must be seen.

// File: rtl/fir_cascade_pkg.sv
package fir_cascade_pkg;
  localparam int NSTAGE = 3;
  localparam int SW     = 2;
  localparam int DW     = 24;
  localparam int TAPW   = 9;
  localparam int DECW   = 4;
  localparam int RNDW   = 2;
  localparam int FRAC   = 23;
  localparam int ACCW   = 2 * DW + TAPW + 1;

  localparam logic signed [ACCW-1:0] HALF_LSB =
    {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [ACCW-1:0] SAT_HI =
    {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SAT_LO =
    {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_MAC  = 2'd2,
    SQ_FIN  = 2'd3
  } seq_state_e;

  // Scale the accumulator back to sample width: optional half-LSB bias,
  // arithmetic shift, then clamp to the signed sample range.
  function automatic logic [DW-1:0] scale_sat(input logic signed [ACCW-1:0] acc,
                                               input logic [RNDW-1:0] mode);
    logic signed [ACCW-1:0] biased;
    logic signed [ACCW-1:0] shifted;
    biased  = (mode == '0) ? acc : acc + HALF_LSB;
    shifted = biased >>> FRAC;
    if (shifted > SAT_HI)      shifted = SAT_HI;
    else if (shifted < SAT_LO) shifted = SAT_LO;
    return shifted[DW-1:0];
  endfunction
endpackage

// File: rtl/fir_coef_ram.sv
module fir_coef_ram
  import fir_cascade_pkg::*;
#(
  parameter int DEPTH = 336,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_val,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          mem_we;
  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    ptr_d  = ptr_q;
    mem_we = 1'b0;
    if (addr_ld) begin
      ptr_d = addr_val;
    end else if (wr_en) begin
      mem_we = (int'(ptr_q) < DEPTH);
      if (ptr_q != '1) ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr_q] <= wr_data;
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;

  // R1: every data write moves the pointer on by exactly one
  assert_ptr_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ld && ptr_q != '1) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R1: an address load takes effect on the next cycle
  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld |=> (ptr_q == $past(addr_val)));
endmodule

// File: rtl/fir_hist_buf.sv
module fir_hist_buf
  import fir_cascade_pkg::*;
#(
  parameter int HAW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic [HAW-1:0] rd_off,
  output logic [DW-1:0]  rd_data
);
  localparam int HDEPTH = 1 << HAW;

  logic [HAW-1:0] wptr_q, wptr_d;
  logic [HAW:0]   fill_q, fill_d;
  logic [HAW-1:0] rd_idx;
  logic [DW-1:0]  mem [HDEPTH];

  always_comb begin
    wptr_d = wptr_q;
    fill_d = fill_q;
    if (wr_en) begin
      wptr_d = wptr_q + 1'b1;
      if (int'(fill_q) < HDEPTH) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  // offset 0 is the newest sample; slots never written read as zero
  assign rd_idx  = wptr_q - 1'b1 - rd_off;
  assign rd_data = ({1'b0, rd_off} < fill_q) ? mem[rd_idx] : '0;

  // R9: history fill level never runs past the buffer depth
  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_q) <= HDEPTH));
  // R2: each stored sample grows the fill level until the buffer is full
  assert_fill_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(fill_q) < HDEPTH) |=> (fill_q == $past(fill_q) + 1'b1));
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq
  import fir_cascade_pkg::*;
#(
  parameter int CAW = 9,
  parameter int HAW = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_ok,
  input  logic [NSTAGE-1:0]            en,
  input  logic [NSTAGE-1:0][TAPW-1:0]  taps,
  input  logic [NSTAGE-1:0][DECW-1:0]  dec,
  input  logic [NSTAGE-1:0][RNDW-1:0]  rnd,
  input  logic [NSTAGE-1:0][CAW-1:0]   base,
  input  logic                         in_valid,
  input  logic [DW-1:0]                in_data,
  output logic [CAW-1:0]               coef_addr,
  input  logic [DW-1:0]                coef_data,
  output logic [NSTAGE-1:0]            hist_wr,
  output logic [DW-1:0]                hist_wdata,
  output logic [HAW-1:0]               hist_off,
  input  logic [NSTAGE-1:0][DW-1:0]    hist_rdata,
  output logic                         out_valid,
  output logic [DW-1:0]                out_data,
  output logic                         ovf
);
  localparam logic [SW-1:0] LAST = SW'(NSTAGE - 1);

  seq_state_e                         st_q, st_d;
  logic [SW-1:0]                      stg_q, stg_d;
  logic [DW-1:0]                      x_q, x_d;
  logic [TAPW-1:0]                    k_q, k_d;
  logic signed [ACCW-1:0]             acc_q, acc_d;
  logic [NSTAGE-1:0][DECW-1:0]        cnt_q, cnt_d;
  logic                               ov_q, ov_d;
  logic [DW-1:0]                      od_q, od_d;
  logic                               ovf_q, ovf_d;

  logic                               push_act;
  logic [SW-1:0]                      push_stg;
  logic [DW-1:0]                      push_x;
  logic [DECW:0]                      dec_eff;
  logic [DECW:0]                      cnt_nxt;
  logic signed [2*DW-1:0]             prod;
  logic [DW-1:0]                      fin_y;

  // a sample enters a filter either straight from the input (idle) or
  // from the previous filter / a bypassed filter (push state)
  assign push_act = ((st_q == SQ_IDLE) && in_valid && cfg_ok) || (st_q == SQ_PUSH);
  assign push_stg = (st_q == SQ_IDLE) ? '0 : stg_q;
  assign push_x   = (st_q == SQ_IDLE) ? in_data : x_q;
  assign dec_eff  = (dec[push_stg] == '0) ? (DECW+1)'(1) : {1'b0, dec[push_stg]};
  assign cnt_nxt  = {1'b0, cnt_q[push_stg]} + 1'b1;

  assign coef_addr  = base[stg_q] + CAW'(k_q);
  assign hist_off   = k_q[HAW-1:0];
  assign hist_wdata = push_x;
  assign prod       = $signed(coef_data) * $signed(hist_rdata[stg_q]);
  assign fin_y      = scale_sat(acc_q, rnd[stg_q]);

  generate
    for (genvar s = 0; s < NSTAGE; s++) begin : g_wr
      assign hist_wr[s] = push_act && (push_stg == SW'(s)) && en[s];
    end
  endgenerate

  always_comb begin
    st_d  = st_q;
    stg_d = stg_q;
    x_d   = x_q;
    k_d   = k_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    ov_d  = 1'b0;
    od_d  = od_q;
    ovf_d = in_valid && (st_q != SQ_IDLE);
    if (push_act) begin
      if (!en[push_stg]) begin
        if (push_stg == LAST) begin
          ov_d = 1'b1;
          od_d = push_x;
          st_d = SQ_IDLE;
        end else begin
          stg_d = push_stg + 1'b1;
          x_d   = push_x;
          st_d  = SQ_PUSH;
        end
      end else if (cnt_nxt >= dec_eff) begin
        cnt_d[push_stg] = '0;
        stg_d = push_stg;
        k_d   = '0;
        acc_d = '0;
        st_d  = SQ_MAC;
      end else begin
        cnt_d[push_stg] = cnt_nxt[DECW-1:0];
        st_d = SQ_IDLE;
      end
    end else begin
      case (st_q)
        SQ_MAC: begin
          acc_d = acc_q + {{(ACCW-2*DW){prod[2*DW-1]}}, prod};
          k_d   = k_q + 1'b1;
          if (k_q == taps[stg_q] - 1'b1) st_d = SQ_FIN;
        end
        SQ_FIN: begin
          if (stg_q == LAST) begin
            ov_d = 1'b1;
            od_d = fin_y;
            st_d = SQ_IDLE;
          end else begin
            x_d   = fin_y;
            stg_d = stg_q + 1'b1;
            st_d  = SQ_PUSH;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      stg_q <= '0;
      x_q   <= '0;
      k_q   <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      stg_q <= stg_d;
      x_q   <= x_d;
      k_q   <= k_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
      ovf_q <= ovf_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign ovf       = ovf_q;

  // independent count of multiply-accumulate cycles for the checker
  logic [TAPW:0] chk_mac_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chk_mac_q <= '0;
    else if (st_q == SQ_MAC) chk_mac_q <= chk_mac_q + 1'b1;
    else                     chk_mac_q <= '0;
  end

  // R10: a result is finalised after exactly T multiply-accumulate cycles
  assert_mac_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FIN) |-> (chk_mac_q == {1'b0, taps[stg_q]}));
  // R8: an input strobed while busy produces an overflow pulse
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && st_q != SQ_IDLE) |=> ovf);
  // R7: with the configuration rejected an idle engine stays idle
  assert_reject_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !cfg_ok) |=> (st_q == SQ_IDLE));
  // R6: output strobe is a single-cycle pulse
  assert_out_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/fir_cascade3.sv
module fir_cascade3
  import fir_cascade_pkg::*;
#(
  parameter int COEF_DEPTH = 336,
  parameter int HIST_AW    = 7,
  localparam int CAW = $clog2(COEF_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSTAGE-1:0]      cfg_en,
  input  logic [NSTAGE*TAPW-1:0] cfg_taps,
  input  logic [NSTAGE*DECW-1:0] cfg_dec,
  input  logic [NSTAGE*RNDW-1:0] cfg_rnd,
  output logic                   cfg_reject,
  input  logic                   coef_addr_ld,
  input  logic [CAW-1:0]         coef_addr,
  input  logic                   coef_wr,
  input  logic [DW-1:0]          coef_data,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_data,
  output logic                   out_valid,
  output logic [DW-1:0]          out_data,
  output logic                   ovf
);
  localparam int HDEPTH = 1 << HIST_AW;
  localparam int SUMW   = CAW + 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSTAGE-1:0][TAPW-1:0] taps_a;
  logic [NSTAGE-1:0][DECW-1:0] dec_a;
  logic [NSTAGE-1:0][RNDW-1:0] rnd_a;
  logic [NSTAGE-1:0][CAW-1:0]  base_a;
  logic [SUMW-1:0]             tap_sum;
  logic                        cfg_bad;
  logic                        ok_q, ok_d;

  assign taps_a = cfg_taps;
  assign dec_a  = cfg_dec;
  assign rnd_a  = cfg_rnd;

  always_comb begin
    tap_sum = '0;
    cfg_bad = 1'b0;
    for (int s = 0; s < NSTAGE; s++) begin
      base_a[s] = tap_sum[CAW-1:0];
      tap_sum   = tap_sum + SUMW'(taps_a[s]);
      if (int'(taps_a[s]) > HDEPTH)         cfg_bad = 1'b1;
      if (cfg_en[s] && taps_a[s] == '0)     cfg_bad = 1'b1;
    end
    if (int'(tap_sum) >= COEF_DEPTH) cfg_bad = 1'b1;
    ok_d = !cfg_bad;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ok_q <= 1'b0;
    else            ok_q <= ok_d;
  end
  assign cfg_reject = !ok_q;

  logic [CAW-1:0]              coef_rd_addr;
  logic [DW-1:0]               coef_rd_data;
  logic [NSTAGE-1:0]           hist_wr;
  logic [DW-1:0]               hist_wdata;
  logic [HIST_AW-1:0]          hist_off;
  logic [NSTAGE-1:0][DW-1:0]   hist_rdata;

  fir_coef_ram #(.DEPTH(COEF_DEPTH)) u_coef (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_ld  (coef_addr_ld),
    .addr_val (coef_addr),
    .wr_en    (coef_wr),
    .wr_data  (coef_data),
    .rd_addr  (coef_rd_addr),
    .rd_data  (coef_rd_data)
  );

  generate
    for (genvar s = 0; s < NSTAGE; s++) begin : g_hist
      fir_hist_buf #(.HAW(HIST_AW)) u_hist (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .wr_en   (hist_wr[s]),
        .wr_data (hist_wdata),
        .rd_off  (hist_off),
        .rd_data (hist_rdata[s])
      );
    end
  endgenerate

  fir_mac_seq #(.CAW(CAW), .HAW(HIST_AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_ok     (ok_q),
    .en         (cfg_en),
    .taps       (taps_a),
    .dec        (dec_a),
    .rnd        (rnd_a),
    .base       (base_a),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .coef_addr  (coef_rd_addr),
    .coef_data  (coef_rd_data),
    .hist_wr    (hist_wr),
    .hist_wdata (hist_wdata),
    .hist_off   (hist_off),
    .hist_rdata (hist_rdata),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .ovf        (ovf)
  );

  // R7: an oversized coefficient layout is flagged on the next cycle
  assert_tap_total_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (int'(tap_sum) >= COEF_DEPTH) |=> cfg_reject);
  // R7: no stored sample changes while the configuration is rejected
  assert_reject_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_reject && in_valid) |-> (hist_wr == '0 || !$stable(cfg_reject) || u_seq.st_q != SQ_IDLE));
endmodule

// File: tb/tb_fir_cascade3.sv
`timescale 1ns/1ps
module tb_fir_cascade3;
  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_en;
  logic [26:0] cfg_taps;
  logic [11:0] cfg_dec;
  logic [5:0]  cfg_rnd;
  logic        cfg_reject;
  logic        coef_addr_ld;
  logic [8:0]  coef_addr;
  logic        coef_wr;
  logic [23:0] coef_data;
  logic        in_valid;
  logic [23:0] in_data;
  logic        out_valid;
  logic [23:0] out_data;
  logic        ovf;

  fir_cascade3 dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_taps(cfg_taps),
    .cfg_dec(cfg_dec), .cfg_rnd(cfg_rnd), .cfg_reject(cfg_reject),
    .coef_addr_ld(coef_addr_ld), .coef_addr(coef_addr), .coef_wr(coef_wr),
    .coef_data(coef_data), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit mon_on = 0;
  int ovf_seen = 0;

  // reference model state
  int coef_m [336];
  int hist_m [3][128];
  int cnt_m  [3];
  int en_m [3], taps_m [3], dec_m [3], rnd_m [3];
  int exp_q [$];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sx24(input logic [23:0] v);
    return int'($signed(v));
  endfunction

  function automatic int scale_m(input longint acc, input int mode);
    longint b;
    b = (mode == 0) ? acc : acc + 64'sd4194304;
    b = b >>> 23;
    if (b > 64'sd8388607)  b = 64'sd8388607;
    if (b < -64'sd8388608) b = -64'sd8388608;
    return int'(b);
  endfunction

  task automatic model_sample(input int x_in);
    int x;
    int base;
    int de;
    longint acc;
    x = x_in;
    base = 0;
    for (int s = 0; s < 3; s++) begin
      if (s > 0) base += taps_m[s-1];
      if (en_m[s] == 0) continue;
      for (int i = 127; i > 0; i--) hist_m[s][i] = hist_m[s][i-1];
      hist_m[s][0] = x;
      de = (dec_m[s] == 0) ? 1 : dec_m[s];
      if (cnt_m[s] + 1 < de) begin
        cnt_m[s]++;
        return;
      end
      cnt_m[s] = 0;
      acc = 0;
      for (int k = 0; k < taps_m[s]; k++)
        acc += longint'(coef_m[base + k]) * longint'(hist_m[s][k]);
      x = scale_m(acc, rnd_m[s]);
    end
    exp_q.push_back(x);
  endtask

  // R6: outputs compared in order against the model
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected output", sx24(out_data), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(sx24(out_data) == e, "R2/R3/R4 output value", sx24(out_data), e);
        end
      end
      if (ovf) ovf_seen++;
    end
  end

  task automatic set_cfg(input int e0, e1, e2, t0, t1, t2, d0, d1, d2, r0, r1, r2);
    en_m = '{e0, e1, e2}; taps_m = '{t0, t1, t2};
    dec_m = '{d0, d1, d2}; rnd_m = '{r0, r1, r2};
    @(negedge clk);
    cfg_en   = {e2[0], e1[0], e0[0]};
    cfg_taps = {t2[8:0], t1[8:0], t0[8:0]};
    cfg_dec  = {d2[3:0], d1[3:0], d0[3:0]};
    cfg_rnd  = {r2[1:0], r1[1:0], r0[1:0]};
    repeat (3) @(negedge clk);
  endtask

  task automatic load_coefs(input int total, input bit tiny);
    @(negedge clk);
    coef_addr_ld = 1'b1; coef_addr = '0;
    @(negedge clk);
    coef_addr_ld = 1'b0;
    for (int i = 0; i < total; i++) begin
      logic [23:0] v;
      v = tiny ? 24'd1 : 24'($urandom);
      coef_m[i] = sx24(v);
      coef_wr = 1'b1; coef_data = v;
      @(negedge clk);
    end
    coef_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [23:0] x, input int gap);
    in_valid = 1'b1; in_data = x;
    model_sample(sx24(x));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_random(input int n, input string tag);
    int gap;
    gap = taps_m[0] + taps_m[1] + taps_m[2] + 10;
    for (int i = 0; i < n; i++) begin
      logic [23:0] x;
      x = ($urandom % 4 == 0) ? 24'($signed($urandom % 8192) - 4096) : 24'($urandom);
      send(x, gap);
    end
    repeat (gap) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 0; in_data = 0; coef_addr_ld = 0; coef_addr = 0;
    coef_wr = 0; coef_data = 0;
    cfg_en = 3'b111; cfg_taps = {9'd4, 9'd3, 9'd4}; cfg_dec = 0; cfg_rnd = 0;
    for (int s = 0; s < 3; s++) begin
      cnt_m[s] = 0;
      for (int i = 0; i < 128; i++) hist_m[s][i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    check(ovf == 1'b0, "R9 ovf after reset", ovf, 0);
    mon_on = 1;

    // R1 R2 R3 R4: decimate by 2 everywhere, rounding 1/0/1
    set_cfg(1,1,1, 4,3,5, 2,2,2, 1,0,1);
    check(cfg_reject == 1'b0, "R7 valid config accepted", cfg_reject, 0);
    load_coefs(12, 0);
    run_random(40, "R2 all decimated outputs delivered");

    // R3: directed rounding with unit coefficients and no decimation
    set_cfg(1,1,1, 1,1,1, 1,1,1, 1,0,3);
    load_coefs(3, 1);
    send(24'h400000, 12); send(24'hC00000, 12); send(24'h7FFFFF, 12);
    // R4: directed saturation with full-scale coefficients
    set_cfg(1,0,0, 2,1,1, 1,0,0, 0,0,0);
    @(negedge clk);
    coef_addr_ld = 1; coef_addr = 0; @(negedge clk); coef_addr_ld = 0;
    coef_wr = 1; coef_data = 24'h800000; coef_m[0] = -8388608; @(negedge clk);
    coef_data = 24'h800000; coef_m[1] = -8388608; @(negedge clk);
    coef_wr = 0; @(negedge clk);
    send(24'h800000, 12); send(24'h800000, 12); send(24'h7FFFFF, 12);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 saturated outputs delivered", exp_q.size(), 0);

    // R5: middle filter bypassed, mixed ratios (0 acts as 1), modes 2/3
    set_cfg(1,0,1, 3,6,5, 1,3,0, 2,1,3);
    load_coefs(14, 0);
    run_random(30, "R5 bypass outputs delivered");

    // R5: all bypassed, output mirrors input
    set_cfg(0,0,0, 2,2,2, 5,5,5, 0,0,0);
    run_random(10, "R5 full bypass outputs delivered");

    // R7: rejection boundaries
    set_cfg(1,1,1, 128,128,80, 1,1,1, 0,0,0);
    check(cfg_reject == 1'b1, "R7 total 336 rejected", cfg_reject, 1);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1; in_data = 24'($urandom); @(negedge clk); in_valid = 0;
      repeat (5) @(negedge clk);
    end
    set_cfg(1,1,1, 128,128,79, 1,1,1, 0,0,0);
    check(cfg_reject == 1'b0, "R7 total 335 accepted", cfg_reject, 0);
    set_cfg(1,1,1, 129,1,1, 1,1,1, 0,0,0);
    check(cfg_reject == 1'b1, "R7 tap count above 128 rejected", cfg_reject, 1);
    set_cfg(1,1,0, 3,0,2, 1,1,1, 0,0,0);
    check(cfg_reject == 1'b1, "R7 enabled filter with zero taps rejected", cfg_reject, 1);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_data = 24'($urandom); @(negedge clk); in_valid = 0;
      repeat (5) @(negedge clk);
    end
    check(exp_q.size() == 0, "R7 rejected inputs produce no output", exp_q.size(), 0);
    // history must be untouched by the ignored samples
    set_cfg(1,1,1, 5,4,3, 2,1,2, 1,1,0);
    load_coefs(12, 0);
    run_random(16, "R7 history intact after rejected inputs");

    // R10: latency with all ratios 1
    set_cfg(1,1,1, 3,4,5, 1,1,1, 0,1,1);
    load_coefs(12, 0);
    begin
      int n;
      in_valid = 1; in_data = 24'h123456; model_sample(sx24(24'h123456));
      @(negedge clk); in_valid = 0;
      n = 0;
      while (!out_valid && n < 200) begin @(negedge clk); n++; end
      check(n == 17, "R10 output latency", n, 17);
      repeat (20) @(negedge clk);
    end

    // R8: a second strobe while computing is dropped and flagged
    set_cfg(1,1,1, 2,2,2, 1,1,1, 1,1,1);
    load_coefs(6, 0);
    ovf_seen = 0;
    in_valid = 1; in_data = 24'h2468AC; model_sample(sx24(24'h2468AC));
    @(negedge clk);
    in_data = 24'h135790;
    @(negedge clk);
    in_valid = 0;
    repeat (30) @(negedge clk);
    check(ovf_seen == 1, "R8 overflow pulse count", ovf_seen, 1);
    run_random(8, "R8 outputs after dropped sample");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule